// File: doc/BRIEF.md
# Interval Timer Host Byte Interface

This block is the byte-wide register front end of a three-channel interval timer. A host reaches it through a 2-bit address. Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2, and address 3 is the control port. Writes to the control port either program a channel, freeze a channel's count, or freeze count and/or status on several channels at once. Writes to a data port assemble a 16-bit initial count, one or two bytes at a time. When the count is complete, the block pulses a load strobe to that channel's counter. Reads from a data port return a frozen status byte, a frozen count, or the channel's live count, one byte at a time.

The counters themselves sit outside this block. Each counter gets a load strobe, a load value, its counting mode and its BCD flag. Each counter returns its live 16-bit count and its output pin level, which this block samples when it takes a snapshot. Only one bus operation happens per cycle. When `wr_en` and `rd_en` are both high, the write is performed and the read is dropped.

Top module: `tmr_host_if`

## Requirements
- R1: A control-port write carries the channel in bits 7:6 (values 0 to 2), the byte access in bits 5:4 (1 = low byte only, 2 = high byte only, 3 = low then high), the counting mode in bits 3:1 and BCD in bit 0. Counting modes 6 and 7 are stored as 2 and 3. A nonzero access value restarts both the write and read byte order of that channel. After reset every channel has access 3, mode 0 and BCD 0.
- R2: In low-only access, a data write loads `{8'h00, byte}`. In high-only access, it loads `{byte, 8'h00}`. The strobe for the channel is high for the one cycle that follows the write's clock edge, with `load_val` valid alongside it.
- R3: In two-byte access, the first data byte is held with no strobe. The second data byte loads `{second, first}`.
- R4: A control write with access 0 snapshots the selected channel's live count. While that snapshot is still unread, further snapshot commands leave it unchanged.
- R5: A control write with bits 7:6 = 3 is a multi-channel command. Bit 1+n selects channel n. Bit 5 = 0 snapshots the count, and bit 4 = 0 snapshots the status.
- R6: The status byte is `{out, 1'b0, access[1:0], mode[2:0], bcd}`, where `out` is the channel's output level at command time. A pending status is not replaced by a later status command.
- R7: A data read returns a pending status first, then a pending count snapshot, then the live count.
- R8: In two-byte access, a count snapshot reads low byte then high byte and is then released. In single-byte access it reads the selected byte once and is released.
- R9: Live reads return the low byte in low-only access and the high byte in high-only access. In two-byte access they alternate low and high, starting with low. Snapshot and status reads do not advance this alternation.
- R10: A read of the control port returns 0 and does not disturb any channel's byte order.
- R11: `rdata` is registered. It shows the read byte from the cycle after the read's clock edge and holds until the next read.
- R12: A control-port write never raises a load strobe, and at most one channel strobes in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the byte in `wdata` |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | 0 to 2 channel data ports, 3 control port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Registered read byte |
| live_cnt | input | 48 | Live counts, channel n at bits 16n+15:16n |
| live_out | input | 3 | Counter output levels, bit n for channel n |
| load_strb | output | 3 | One-cycle count-load strobe per channel |
| load_val | output | 48 | Count to load, channel n at bits 16n+15:16n |
| cfg_mode | output | 9 | Counting mode, channel n at bits 3n+2:3n |
| cfg_bcd | output | 3 | BCD flag per channel |

## Verification
Every result of this block appears exactly one clock edge after the bus operation that causes it. A read byte appears in `rdata`, and a completed count write appears on `load_strb` and `load_val`. Sequencer and snapshot state also move on that same edge. The bench drives each operation at a falling edge and removes it at the next falling edge, so exactly one rising edge falls in between. It then samples the outputs at that second falling edge. To check that a strobe lasts one cycle, the bench waits one further falling edge. Live counts and output levels are changed only between operations, which makes it visible whether a snapshot was taken at its command's edge or at a later one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } acc_e;

  // Counting modes above 5 alias onto 2 and 3.
  function automatic logic [2:0] fold_mode(input logic [2:0] m);
    return (m > 3'd5) ? (m - 3'd4) : m;
  endfunction

  function automatic logic [BYTE_W-1:0] pack_status(input logic out_lvl,
                                                    input logic [1:0] acc,
                                                    input logic [2:0] mode,
                                                    input logic bcd);
    return {out_lvl, 1'b0, acc, mode, bcd};
  endfunction

  // Count produced by a single-byte write.
  function automatic logic [CNT_W-1:0] single_load(input logic [1:0] acc,
                                                   input logic [BYTE_W-1:0] b);
    return (acc == ACC_HI) ? {b, {BYTE_W{1'b0}}} : {{BYTE_W{1'b0}}, b};
  endfunction

endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [NUM_CH-1:0] prog,
  output logic [NUM_CH-1:0] snap_cnt,
  output logic [NUM_CH-1:0] snap_sts,
  output logic [NUM_CH-1:0] data_wr,
  output logic [NUM_CH-1:0] data_rd,
  output logic              ctrl_rd
);
  localparam logic [1:0] CTRL_ADDR = 2'd3;

  logic is_ctrl;
  assign is_ctrl = (addr == CTRL_ADDR);

  always_comb begin
    prog     = '0;
    snap_cnt = '0;
    snap_sts = '0;
    data_wr  = '0;
    data_rd  = '0;
    ctrl_rd  = rd_en && !wr_en && is_ctrl;
    if (wr_en && is_ctrl) begin
      if (wdata[7:6] == 2'd3) begin
        for (int n = 0; n < NUM_CH; n++) begin
          if (wdata[1+n]) begin
            snap_cnt[n] = !wdata[5];
            snap_sts[n] = !wdata[4];
          end
        end
      end else begin
        for (int n = 0; n < NUM_CH; n++) begin
          if (wdata[7:6] == n[1:0]) begin
            if (wdata[5:4] == ACC_LATCH) snap_cnt[n] = 1'b1;
            else                         prog[n]     = 1'b1;
          end
        end
      end
    end else begin
      for (int n = 0; n < NUM_CH; n++) begin
        if (addr == n[1:0]) begin
          data_wr[n] = wr_en;
          data_rd[n] = rd_en && !wr_en;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog,
  input  logic              snap_cnt,
  input  logic              snap_sts,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live_cnt,
  input  logic              live_out,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              load_strb,
  output logic [CNT_W-1:0]  load_val,
  output logic [1:0]        acc,
  output logic [2:0]        mode,
  output logic              bcd
);
  logic              wr_hi_q;   // next write byte is the high byte
  logic              rd_hi_q;   // next live read is the high byte
  logic [BYTE_W-1:0] hold_q;
  logic              sts_pend_q;
  logic [BYTE_W-1:0] sts_q;
  logic [1:0]        snap_st_q; // 0 none, else access order of the snapshot
  logic [CNT_W-1:0]  snap_q;

  logic [BYTE_W-1:0] live_byte;
  always_comb begin
    case (acc)
      ACC_HI:   live_byte = live_cnt[CNT_W-1:BYTE_W];
      ACC_WORD: live_byte = rd_hi_q ? live_cnt[CNT_W-1:BYTE_W]
                                    : live_cnt[BYTE_W-1:0];
      default:  live_byte = live_cnt[BYTE_W-1:0];
    endcase
  end

  always_comb begin
    if (sts_pend_q)                rd_byte = sts_q;
    else if (snap_st_q == ACC_HI)  rd_byte = snap_q[CNT_W-1:BYTE_W];
    else if (snap_st_q != 2'd0)    rd_byte = snap_q[BYTE_W-1:0];
    else                           rd_byte = live_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc        <= ACC_WORD;
      mode       <= 3'd0;
      bcd        <= 1'b0;
      wr_hi_q    <= 1'b0;
      rd_hi_q    <= 1'b0;
      hold_q     <= '0;
      load_strb  <= 1'b0;
      load_val   <= '0;
      sts_pend_q <= 1'b0;
      sts_q      <= '0;
      snap_st_q  <= 2'd0;
      snap_q     <= '0;
    end else begin
      load_strb <= 1'b0;
      if (prog) begin
        acc     <= wdata[5:4];
        mode    <= fold_mode(wdata[3:1]);
        bcd     <= wdata[0];
        wr_hi_q <= 1'b0;
        rd_hi_q <= 1'b0;
      end
      if (data_wr) begin
        if (acc != ACC_WORD) begin
          load_strb <= 1'b1;
          load_val  <= single_load(acc, wdata);
        end else if (!wr_hi_q) begin
          hold_q  <= wdata;
          wr_hi_q <= 1'b1;
        end else begin
          load_strb <= 1'b1;
          load_val  <= {wdata, hold_q};
          wr_hi_q   <= 1'b0;
        end
      end
      if (snap_cnt && snap_st_q == 2'd0) begin
        snap_q    <= live_cnt;
        snap_st_q <= acc;
      end
      if (snap_sts && !sts_pend_q) begin
        sts_q      <= pack_status(live_out, acc, mode, bcd);
        sts_pend_q <= 1'b1;
      end
      if (data_rd) begin
        if (sts_pend_q)                 sts_pend_q <= 1'b0;
        else if (snap_st_q == ACC_WORD) snap_st_q  <= ACC_HI;
        else if (snap_st_q != 2'd0)     snap_st_q  <= 2'd0;
        else if (acc == ACC_WORD)       rd_hi_q    <= ~rd_hi_q;
      end
    end
  end
endmodule

// File: rtl/tmr_read_mux.sv
module tmr_read_mux
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_take,
  input  logic [1:0]               addr,
  input  logic [NUM_CH*BYTE_W-1:0] bytes_in,
  output logic [BYTE_W-1:0]        rdata
);
  logic [BYTE_W-1:0] pick;
  always_comb begin
    pick = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (addr == n[1:0]) pick = bytes_in[n*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rdata <= '0;
    else if (rd_take) rdata <= pick;
  end
endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3,
  localparam int CW = CNT_W,
  localparam int BW = BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [1:0]           addr,
  input  logic [BW-1:0]        wdata,
  output logic [BW-1:0]        rdata,
  input  logic [NUM_CH*CW-1:0] live_cnt,
  input  logic [NUM_CH-1:0]    live_out,
  output logic [NUM_CH-1:0]    load_strb,
  output logic [NUM_CH*CW-1:0] load_val,
  output logic [NUM_CH*3-1:0]  cfg_mode,
  output logic [NUM_CH-1:0]    cfg_bcd
);
  logic [NUM_CH-1:0]    prog, snap_cnt, snap_sts, data_wr, data_rd;
  logic                 ctrl_rd;
  logic [NUM_CH*BW-1:0] byte_all;
  logic [NUM_CH*2-1:0]  acc_w;
  logic                 rd_take;

  tmr_cmd_decode #(.NUM_CH(NUM_CH)) u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .prog(prog), .snap_cnt(snap_cnt), .snap_sts(snap_sts),
    .data_wr(data_wr), .data_rd(data_rd), .ctrl_rd(ctrl_rd)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    tmr_chan_port u_ch (
      .clk(clk), .rst_n(rst_n),
      .prog(prog[g]), .snap_cnt(snap_cnt[g]), .snap_sts(snap_sts[g]),
      .data_wr(data_wr[g]), .data_rd(data_rd[g]), .wdata(wdata),
      .live_cnt(live_cnt[g*CW +: CW]), .live_out(live_out[g]),
      .rd_byte(byte_all[g*BW +: BW]),
      .load_strb(load_strb[g]), .load_val(load_val[g*CW +: CW]),
      .acc(acc_w[g*2 +: 2]), .mode(cfg_mode[g*3 +: 3]), .bcd(cfg_bcd[g])
    );
  end

  // Control-port reads select nothing, so the mux returns zero for them.
  assign rd_take = (|data_rd) || ctrl_rd;

  tmr_read_mux #(.NUM_CH(NUM_CH)) u_rmux (
    .clk(clk), .rst_n(rst_n), .rd_take(rd_take), .addr(addr),
    .bytes_in(byte_all), .rdata(rdata)
  );
endmodule

// File: rtl/tmr_host_if_chk.sv
module tmr_host_if_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [1:0]  addr,
  input logic [7:0]  rdata,
  input logic [2:0]  load_strb,
  input logic [47:0] load_val,
  input logic [5:0]  acc_w
);
  AST_STRB_FROM_DATA_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|load_strb) |-> ($past(wr_en) && $past(addr) != 2'd3)); // R12
  AST_STRB_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_strb)); // R12
  AST_CTRL_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en && !wr_en && addr == 2'd3) |-> (rdata == 8'h00)); // R10
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en && !wr_en) |-> $stable(rdata)); // R11
  AST_LO_ONLY_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (load_strb[0] && acc_w[1:0] == 2'd1) |-> (load_val[15:8] == 8'h00)); // R2
  AST_HI_ONLY_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (load_strb[0] && acc_w[1:0] == 2'd2) |-> (load_val[7:0] == 8'h00)); // R2
endmodule

bind tmr_host_if tmr_host_if_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .load_strb(load_strb), .load_val(load_val), .acc_w(acc_w)
);

// File: tb/tmr_host_if_test.sv
module tmr_host_if_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic [47:0] live_cnt = 48'h0;
  logic [2:0]  live_out = 3'b000;
  logic [2:0]  load_strb;
  logic [47:0] load_val;
  logic [8:0]  cfg_mode;
  logic [2:0]  cfg_bcd;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  tmr_host_if uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .live_cnt(live_cnt), .live_out(live_out),
    .load_strb(load_strb), .load_val(load_val), .cfg_mode(cfg_mode),
    .cfg_bcd(cfg_bcd)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, {8'h00, d}, {8'h00, exp});
  endtask

  task automatic t_reset;
    chk("R11 rdata after reset", {8'h00, rdata}, 16'h0000);
    chk("R12 no strobe after reset", {13'h0, load_strb}, 16'h0000);
    chk("R1 reset mode", {7'h0, cfg_mode}, 16'h0000);
    chk("R1 reset bcd", {13'h0, cfg_bcd}, 16'h0000);
  endtask

  task automatic t_lsb_only;
    wr(2'd3, 8'h15);                 // ch0, low only, mode 2, BCD
    chk("R12 no strobe on control write", {13'h0, load_strb}, 16'h0000);
    chk("R1 ch0 mode", {13'h0, cfg_mode[2:0]}, 16'h0002);
    chk("R1 ch0 bcd", {15'h0, cfg_bcd[0]}, 16'h0001);
    wr(2'd0, 8'hA5);
    chk("R2 low-only strobe", {13'h0, load_strb}, 16'h0001);
    chk("R2 low-only value", load_val[15:0], 16'h00A5);
    @(negedge clk);
    chk("R2 strobe lasts one cycle", {13'h0, load_strb}, 16'h0000);
    live_cnt[15:0] = 16'h1234;
    rd_chk("R9 low-only live read", 2'd0, 8'h34);
    rd_chk("R9 low-only live read again", 2'd0, 8'h34);
  endtask

  task automatic t_msb_only;
    wr(2'd3, 8'h6E);                 // ch1, high only, mode 7
    chk("R1 mode 7 folds to 3", {13'h0, cfg_mode[5:3]}, 16'h0003);
    wr(2'd1, 8'h5C);
    chk("R2 high-only strobe", {13'h0, load_strb}, 16'h0002);
    chk("R2 high-only value", load_val[31:16], 16'h5C00);
    live_cnt[31:16] = 16'hBEEF;
    rd_chk("R9 high-only live read", 2'd1, 8'hBE);
  endtask

  task automatic t_word;
    wr(2'd3, 8'hB6);                 // ch2, two-byte, mode 3
    wr(2'd2, 8'h34);
    chk("R3 no strobe on first byte", {13'h0, load_strb}, 16'h0000);
    wr(2'd2, 8'h12);
    chk("R3 strobe on second byte", {13'h0, load_strb}, 16'h0004);
    chk("R3 two-byte value", load_val[47:32], 16'h1234);
    live_cnt[47:32] = 16'hCAFE;
    rd_chk("R9 alternating low", 2'd2, 8'hFE);
    rd_chk("R9 alternating high", 2'd2, 8'hCA);
    rd_chk("R9 alternating low again", 2'd2, 8'hFE);
    wr(2'd3, 8'hB6);
    rd_chk("R1 reprogram restarts read order", 2'd2, 8'hFE);
    wr(2'd2, 8'h11);
    wr(2'd3, 8'hB6);
    wr(2'd2, 8'h22);
    chk("R1 reprogram restarts write order", {13'h0, load_strb}, 16'h0000);
    wr(2'd2, 8'h33);
    chk("R1 reprogram restarts write order value", load_val[47:32], 16'h3322);
    wr(2'd3, 8'hB6);                 // read order back to low
  endtask

  task automatic t_latch;
    wr(2'd3, 8'h80);                 // snapshot ch2 (0xCAFE)
    live_cnt[47:32] = 16'h1111;
    wr(2'd3, 8'h80);                 // ignored, snapshot pending
    rd_chk("R4 snapshot low byte", 2'd2, 8'hFE);
    rd_chk("R8 snapshot high byte", 2'd2, 8'hCA);
    rd_chk("R8 released then live", 2'd2, 8'h11);
    wr(2'd3, 8'h00);                 // snapshot ch0 (0x1234)
    live_cnt[15:0] = 16'h5678;
    rd_chk("R8 low-only snapshot", 2'd0, 8'h34);
    rd_chk("R8 low-only released", 2'd0, 8'h78);
    live_cnt[31:16] = 16'hBEEF;
    wr(2'd3, 8'h40);                 // snapshot ch1
    live_cnt[31:16] = 16'h0102;
    rd_chk("R8 high-only snapshot", 2'd1, 8'hBE);
    rd_chk("R8 high-only released", 2'd1, 8'h01);
  endtask

  task automatic t_readback;
    live_out = 3'b001;
    live_cnt[15:0]  = 16'h4321;
    live_cnt[31:16] = 16'h7788;
    wr(2'd3, 8'hC6);                 // count+status on ch0 and ch1
    live_out = 3'b000;
    wr(2'd3, 8'hE2);                 // status only ch0: ignored, pending
    live_cnt[15:0]  = 16'h9999;
    live_cnt[31:16] = 16'h3344;
    rd_chk("R6 R7 ch0 status first", 2'd0, 8'h95);
    rd_chk("R7 ch0 snapshot next", 2'd0, 8'h21);
    rd_chk("R7 ch0 live last", 2'd0, 8'h99);
    rd_chk("R5 R6 ch1 status", 2'd1, 8'h26);
    rd_chk("R5 ch1 snapshot", 2'd1, 8'h77);
    rd_chk("R5 ch1 live", 2'd1, 8'h33);
    rd_chk("R5 ch2 not selected", 2'd2, 8'h11);
    live_cnt[47:32] = 16'hABCD;
    wr(2'd3, 8'hD8);                 // count only on ch2
    live_cnt[47:32] = 16'h0000;
    rd_chk("R5 ch2 count-only low", 2'd2, 8'hCD);
    rd_chk("R5 ch2 count-only high", 2'd2, 8'hAB);
  endtask

  task automatic t_ctrl_read;
    logic [7:0] d;
    wr(2'd3, 8'hB6);
    live_cnt[47:32] = 16'h5A6B;
    rd_chk("R10 ch2 low", 2'd2, 8'h6B);
    rd_chk("R10 control read is zero", 2'd3, 8'h00);
    rd_chk("R10 ch2 order undisturbed", 2'd2, 8'h5A);
    rd(2'd2, d);
    repeat (3) @(negedge clk);
    chk("R11 rdata holds without reads", {8'h00, rdata}, {8'h00, d});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_lsb_only;
    t_msb_only;
    t_word;
    t_latch;
    t_readback;
    t_ctrl_read;
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule